// File: doc/BRIEF.md
# Two-Step Register Write Guard

This block sits behind the byte-level front end of a two-wire serial slave and decides whether a write transaction may change a clock/control register space. The front end hands it single-cycle events: a start condition, a stop condition, an abort (for example a malformed byte), and a completed byte with its value. The first byte after a start is the slave byte. Its upper seven bits select the device and its lowest bit is 1 for a read. In a write, the second byte is the register address and the bytes after it are data.

Two volatile latches guard the writes. Writing one value to the status register arms the general enable. A second value arms both the general enable and the register enable. Data bytes for the volatile time bank or the non-volatile control bank are held in a staging buffer. They reach the register file only when the transaction closes with a stop, the byte count is legal for that bank, and both latches are armed. A successful commit drops the register enable, so each change needs a fresh unlock. A commit to the control bank starts a busy window. During that window new write transactions are refused, while reads are still answered.

Events must arrive at least nine clock cycles apart, so that a commit has finished draining before the next data byte is staged.

Top module: `reg_write_guard`

## Requirements
- R1: After reset, wel, rwel, busy, ack_valid and commit_valid are all 0.
- R2: A legal one-byte write to status address 0x3F acts only on the values 0x02 (sets wel, rwel unchanged), 0x06 (sets wel and rwel) and 0x00 (clears both). Any other value leaves both latches unchanged. rwel is never 1 while wel is 0.
- R3: A slave byte whose bits [7:1] equal 7'b1101111 is acknowledged (ack_valid=1, ack=1, one cycle after the byte). Any other slave byte gives ack_valid=1, ack=0, and the rest of the transaction is ignored.
- R4: The time bank is addresses 0x30 to 0x37. A write there commits only when it starts at 0x30 and carries exactly 8 data bytes.
- R5: The control bank is addresses 0x10 to 0x14. A write there commits only with 1 to 5 data bytes that do not run past 0x14.
- R6: A commit clears rwel and leaves wel set.
- R7: A transaction with an illegal byte count, one hit by an abort, or one cut off by a repeated start commits nothing and leaves both latches unchanged.
- R8: A write to any address outside the status register and the two banks commits nothing and leaves both latches unchanged.
- R9: A commit to the control bank holds busy high for exactly BUSY_CYCLES cycles, starting in the cycle after the stop. While busy, a write slave byte gets ack=0. A time bank commit does not raise busy.
- R10: A read transaction (slave byte bit 0 = 1) is acknowledged even while busy, commits nothing and leaves both latches unchanged.
- R11: A bank write commits nothing unless wel and rwel are both 1 when the stop arrives.
- R12: A commit presents one beat per cycle on commit_valid/commit_addr/commit_data, starting in the cycle after the stop. Beats carry ascending addresses starting at the first register address, and the data bytes in the order they arrived.
- R13: A data byte beyond the eighth in a transaction gets ack=0, and that transaction commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start or repeated start seen on the bus |
| ev_stop | input | 1 | Stop seen on the bus |
| ev_abort | input | 1 | Current transaction is malformed |
| ev_byte | input | 1 | A byte has completed |
| ev_data | input | 8 | Value of the completed byte |
| ack_valid | output | 1 | Acknowledge decision is present for the last byte |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| wel | output | 1 | General write enable latch |
| rwel | output | 1 | Register write enable latch |
| busy | output | 1 | Non-volatile busy window active |
| commit_valid | output | 1 | A committed byte is presented this cycle |
| commit_addr | output | 8 | Register address of the committed byte |
| commit_data | output | 8 | Committed byte value |

## Verification
On every cycle the checker enforces that rwel never stands alone, that a commit burst starts only when both latches were armed and leaves rwel cleared, that busy rises only together with a commit, that beat addresses climb by one, and that an acknowledge decision only follows a byte. The scenarios are the only way to show which transactions commit and which do not: wrong counts, misaligned time writes, control writes that cross the end of the bank, aborts, repeated starts, undefined addresses, refused slave bytes and ninth data bytes. They also cover the exact busy length, refusal of writes during busy, and the fact that reads pass untouched.

// File: rtl/rwg_pkg.sv
package rwg_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      RG_NONE,
      RG_STATUS,
      RG_TIME,
      RG_CTRL
   } rwg_region_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_ADDR,
      PH_DATA,
      PH_READ,
      PH_SKIP
   } rwg_phase_e;

   localparam logic [BYTE_W-1:0] SR_ARM_WEL  = 8'h02;
   localparam logic [BYTE_W-1:0] SR_ARM_BOTH = 8'h06;
   localparam logic [BYTE_W-1:0] SR_DISARM   = 8'h00;

endpackage

// File: rtl/rwg_region_dec.sv
module rwg_region_dec
   import rwg_pkg::*;
#(
   parameter logic [7:0] STATUS_ADDR = 8'h3F,
   parameter logic [7:0] TIME_BASE   = 8'h30,
   parameter int         TIME_LEN    = 8,
   parameter logic [7:0] CTRL_BASE   = 8'h10,
   parameter int         CTRL_LEN    = 5
) (
   input  logic [BYTE_W-1:0] addr,
   output rwg_region_e       region,
   output logic [BYTE_W-1:0] offset
);

   localparam int TIME_LAST = int'(TIME_BASE) + TIME_LEN - 1;
   localparam int CTRL_LAST = int'(CTRL_BASE) + CTRL_LEN - 1;

   always_comb begin
      region = RG_NONE;
      offset = '0;
      if (addr == STATUS_ADDR) begin
         region = RG_STATUS;
      end else if (int'(addr) >= int'(TIME_BASE) && int'(addr) <= TIME_LAST) begin
         region = RG_TIME;
         offset = addr - TIME_BASE;
      end else if (int'(addr) >= int'(CTRL_BASE) && int'(addr) <= CTRL_LAST) begin
         region = RG_CTRL;
         offset = addr - CTRL_BASE;
      end
   end

endmodule

// File: rtl/rwg_latches.sv
module rwg_latches
   import rwg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sr_wr,
   input  logic [BYTE_W-1:0] sr_val,
   input  logic              clr_rwel,
   output logic              wel,
   output logic              rwel
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         rwel <= 1'b0;
      end else if (sr_wr) begin
         case (sr_val)
            SR_ARM_WEL:  wel <= 1'b1;
            SR_ARM_BOTH: begin
               wel  <= 1'b1;
               rwel <= 1'b1;
            end
            SR_DISARM: begin
               wel  <= 1'b0;
               rwel <= 1'b0;
            end
            default: ;
         endcase
      end else if (clr_rwel) begin
         rwel <= 1'b0;
      end
   end

endmodule

// File: rtl/rwg_stage.sv
module rwg_stage
   import rwg_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CNT_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic [BYTE_W-1:0] load_addr,
   output logic [BYTE_W-1:0] first_byte,
   output logic              beat_valid,
   output logic [BYTE_W-1:0] beat_addr,
   output logic [BYTE_W-1:0] beat_data
);

   logic [BYTE_W-1:0] slot_q [DEPTH];
   logic [CNT_W-1:0]  idx_q;
   logic [CNT_W-1:0]  left_q;
   logic [BYTE_W-1:0] base_q;

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[s] <= '0;
         end else if (wr_en && wr_idx == CNT_W'(s)) begin
            slot_q[s] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         left_q <= '0;
         base_q <= '0;
      end else if (load) begin
         idx_q  <= '0;
         left_q <= load_cnt;
         base_q <= load_addr;
      end else if (left_q != '0) begin
         idx_q  <= idx_q + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   always_comb begin
      beat_data = '0;
      for (int s = 0; s < DEPTH; s++) begin
         if (idx_q == CNT_W'(s)) beat_data = slot_q[s];
      end
   end

   assign first_byte = slot_q[0];
   assign beat_valid = (left_q != '0);
   assign beat_addr  = base_q + BYTE_W'(idx_q);

endmodule

// File: rtl/rwg_busy.sv
module rwg_busy #(
   parameter int BUSY_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   if (BUSY_CYCLES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy <= 1'b0;
         else        busy <= start;
      end
   end else begin : g_count
      localparam int BW = $clog2(BUSY_CYCLES + 1);
      logic [BW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left_q <= '0;
         else if (start)          left_q <= BW'(BUSY_CYCLES);
         else if (left_q != '0)   left_q <= left_q - 1'b1;
      end
      assign busy = (left_q != '0);
   end

endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard
   import rwg_pkg::*;
#(
   parameter logic [6:0] SLAVE_ID    = 7'b1101111,
   parameter logic [7:0] STATUS_ADDR = 8'h3F,
   parameter logic [7:0] TIME_BASE   = 8'h30,
   parameter int         TIME_LEN    = 8,
   parameter logic [7:0] CTRL_BASE   = 8'h10,
   parameter int         CTRL_LEN    = 5,
   parameter int         BUSY_CYCLES = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start,
   input  logic       ev_stop,
   input  logic       ev_abort,
   input  logic       ev_byte,
   input  logic [7:0] ev_data,
   output logic       ack_valid,
   output logic       ack,
   output logic       wel,
   output logic       rwel,
   output logic       busy,
   output logic       commit_valid,
   output logic [7:0] commit_addr,
   output logic [7:0] commit_data
);

   localparam int DEPTH = (TIME_LEN > CTRL_LEN) ? TIME_LEN : CTRL_LEN;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (TIME_LEN < 1 || CTRL_LEN < 1) begin : g_bad_len
      $error("bank lengths must be at least one byte");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least one");
   end
   if (int'(TIME_BASE) + TIME_LEN > 256 || int'(CTRL_BASE) + CTRL_LEN > 256) begin : g_bad_span
      $error("bank exceeds the byte address space");
   end
   if (!(int'(CTRL_BASE) + CTRL_LEN <= int'(TIME_BASE) ||
         int'(TIME_BASE) + TIME_LEN <= int'(CTRL_BASE))) begin : g_bad_overlap
      $error("time and control banks overlap");
   end

   rwg_phase_e        phase_q;
   logic [7:0]        addr_q;
   logic [CNT_W-1:0]  count_q;
   logic              ovf_q;
   logic              ack_valid_q;
   logic              ack_q;

   rwg_region_e       region;
   logic [7:0]        offset;
   logic [7:0]        first_byte;
   logic              id_match;
   logic              full;
   logic              at_stop;
   logic              legal_sr;
   logic              legal_time;
   logic              legal_ctrl;
   logic              commit_go;
   logic              sr_wr;
   logic              busy_go;
   logic              stage_wr;

   rwg_region_dec #(
      .STATUS_ADDR (STATUS_ADDR),
      .TIME_BASE   (TIME_BASE),
      .TIME_LEN    (TIME_LEN),
      .CTRL_BASE   (CTRL_BASE),
      .CTRL_LEN    (CTRL_LEN)
   ) i_dec (
      .addr   (addr_q),
      .region (region),
      .offset (offset)
   );

   assign id_match = (ev_data[7:1] == SLAVE_ID);
   assign full     = (count_q == CNT_W'(DEPTH));
   assign stage_wr = ev_byte && !ev_start && !ev_abort && !ev_stop &&
                     (phase_q == PH_DATA) && !full;

   assign at_stop    = ev_stop && !ev_start && !ev_abort && (phase_q == PH_DATA) && !ovf_q;
   assign legal_sr   = (region == RG_STATUS) && (count_q == CNT_W'(1));
   assign legal_time = (region == RG_TIME) && (offset == 8'd0) &&
                       (count_q == CNT_W'(TIME_LEN));
   assign legal_ctrl = (region == RG_CTRL) && (count_q != '0) &&
                       ((int'(offset) + int'(count_q)) <= CTRL_LEN);

   assign sr_wr     = at_stop && legal_sr;
   assign commit_go = at_stop && (legal_time || legal_ctrl) && wel && rwel;
   assign busy_go   = commit_go && (region == RG_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         addr_q      <= '0;
         count_q     <= '0;
         ovf_q       <= 1'b0;
         ack_valid_q <= 1'b0;
         ack_q       <= 1'b0;
      end else begin
         ack_valid_q <= 1'b0;
         ack_q       <= 1'b0;
         if (ev_start) begin
            phase_q <= PH_DEV;
            count_q <= '0;
            ovf_q   <= 1'b0;
         end else if (ev_abort) begin
            if (phase_q != PH_IDLE) phase_q <= PH_SKIP;
         end else if (ev_stop) begin
            phase_q <= PH_IDLE;
         end else if (ev_byte) begin
            case (phase_q)
               PH_DEV: begin
                  ack_valid_q <= 1'b1;
                  if (id_match && ev_data[0]) begin
                     ack_q   <= 1'b1;
                     phase_q <= PH_READ;
                  end else if (id_match && !busy) begin
                     ack_q   <= 1'b1;
                     phase_q <= PH_ADDR;
                  end else begin
                     phase_q <= PH_SKIP;
                  end
               end
               PH_ADDR: begin
                  ack_valid_q <= 1'b1;
                  ack_q       <= 1'b1;
                  addr_q      <= ev_data;
                  phase_q     <= PH_DATA;
               end
               PH_DATA: begin
                  ack_valid_q <= 1'b1;
                  if (!full) begin
                     ack_q   <= 1'b1;
                     count_q <= count_q + 1'b1;
                  end else begin
                     ovf_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   rwg_stage #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
   ) i_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (stage_wr),
      .wr_idx     (count_q),
      .wr_data    (ev_data),
      .load       (commit_go),
      .load_cnt   (count_q),
      .load_addr  (addr_q),
      .first_byte (first_byte),
      .beat_valid (commit_valid),
      .beat_addr  (commit_addr),
      .beat_data  (commit_data)
   );

   rwg_latches i_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .sr_wr    (sr_wr),
      .sr_val   (first_byte),
      .clr_rwel (commit_go),
      .wel      (wel),
      .rwel     (rwel)
   );

   rwg_busy #(
      .BUSY_CYCLES (BUSY_CYCLES)
   ) i_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (busy_go),
      .busy  (busy)
   );

   assign ack_valid = ack_valid_q;
   assign ack       = ack_q;

endmodule

// File: rtl/rwg_checker.sv
module rwg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_byte,
   input logic       ack_valid,
   input logic       wel,
   input logic       rwel,
   input logic       busy,
   input logic       commit_valid,
   input logic [7:0] commit_addr
);

   // R2: the register enable is only ever armed together with the general enable
   assert_rwel_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rwel |-> wel);

   // R11: a burst only begins if both latches were armed at the stop
   assert_commit_unlocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(commit_valid) |-> ($past(wel) && $past(rwel)));

   // R6: the burst starts with rwel dropped and wel kept
   assert_commit_clears_rwel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(commit_valid) |-> (!rwel && wel));

   // R9: busy only opens with a fresh commit burst
   assert_busy_with_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $rose(commit_valid));

   // R12: consecutive beats climb by one address
   assert_beat_ascending_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && $past(commit_valid)) |-> (commit_addr == $past(commit_addr) + 8'd1));

   // R3: an acknowledge decision only follows a completed byte
   assert_ack_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(ev_byte));

endmodule

bind reg_write_guard rwg_checker i_rwg_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .ev_byte      (ev_byte),
   .ack_valid    (ack_valid),
   .wel          (wel),
   .rwel         (rwel),
   .busy         (busy),
   .commit_valid (commit_valid),
   .commit_addr  (commit_addr)
);

// File: tb/test_reg_write_guard.sv
`timescale 1ns/1ps
module test_reg_write_guard;

   localparam int BUSY = 60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_start = 1'b0, ev_stop = 1'b0, ev_abort = 1'b0, ev_byte = 1'b0;
   logic [7:0] ev_data = '0;
   logic       ack_valid, ack, wel, rwel, busy, commit_valid;
   logic [7:0] commit_addr, commit_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] q_addr[$];
   logic [7:0] q_data[$];

   bit m_wel = 0, m_rwel = 0;
   int busy_run = 0, last_busy_run = 0;

   always #5 clk = ~clk;

   reg_write_guard #(.BUSY_CYCLES(BUSY)) i_reg_write_guard (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_abort(ev_abort), .ev_byte(ev_byte), .ev_data(ev_data),
      .ack_valid(ack_valid), .ack(ack), .wel(wel), .rwel(rwel), .busy(busy),
      .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops expected beats as the design presents them
   always @(negedge clk) begin
      if (rst_n && commit_valid) begin
         if (q_addr.size() == 0) begin
            check(0, "R12 unexpected commit beat", int'(commit_addr), 0);
         end else begin
            logic [7:0] ea, ed;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            check(commit_addr == ea && commit_data == ed, "R12 beat addr/data",
                  int'({commit_addr, commit_data}), int'({ea, ed}));
         end
      end
      if (rst_n) begin
         if (busy) busy_run++;
         else if (busy_run != 0) begin
            last_busy_run = busy_run;
            busy_run = 0;
         end
      end
   end

   function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
      return seed + 8'(i * 37);
   endfunction

   task automatic ev_pulse(input int which);
      @(negedge clk);
      case (which)
         0: ev_start = 1'b1;
         1: ev_stop  = 1'b1;
         default: ev_abort = 1'b1;
      endcase
      @(negedge clk);
      ev_start = 1'b0; ev_stop = 1'b0; ev_abort = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b, output logic av, output logic ak);
      @(negedge clk);
      ev_byte = 1'b1; ev_data = b;
      @(negedge clk);
      ev_byte = 1'b0;
      av = ack_valid; ak = ack;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_latches(input string req);
      check(wel == m_wel, {req, " wel"}, int'(wel), int'(m_wel));
      check(rwel == m_rwel, {req, " rwel"}, int'(rwel), int'(m_rwel));
   endtask

   // full write transaction with its expected outcome
   task automatic do_write(input logic [7:0] addr, input int n, input logic [7:0] seed,
                           input string req);
      logic av, ak;
      bit is_sr, is_time, is_ctrl, legal;
      ev_pulse(0);
      send(8'hDE, av, ak);
      check(av && ak, {req, " R3 slave byte ack"}, int'({av, ak}), 3);
      send(addr, av, ak);
      for (int i = 0; i < n; i++) begin
         send(dbyte(seed, i), av, ak);
         if (i < 8) check(av && ak, {req, " data ack"}, int'({av, ak}), 3);
         else       check(av && !ak, {req, " R13 ninth byte nack"}, int'({av, ak}), 2);
      end
      is_sr   = (addr == 8'h3F);
      is_time = (addr >= 8'h30 && addr <= 8'h37);
      is_ctrl = (addr >= 8'h10 && addr <= 8'h14);
      if (is_sr && n == 1) begin
         if (seed == 8'h02) m_wel = 1;
         else if (seed == 8'h06) begin m_wel = 1; m_rwel = 1; end
         else if (seed == 8'h00) begin m_wel = 0; m_rwel = 0; end
      end
      legal = (is_time && addr == 8'h30 && n == 8) ||
              (is_ctrl && n >= 1 && n <= 8 && (int'(addr) - 16 + n) <= 5);
      if (legal && m_wel && m_rwel) begin
         for (int i = 0; i < n; i++) begin
            q_addr.push_back(addr + 8'(i));
            q_data.push_back(dbyte(seed, i));
         end
         m_rwel = 0;
      end
      ev_pulse(1);
      repeat (8) @(negedge clk);
      check(q_addr.size() == 0, {req, " expected beats drained"}, q_addr.size(), 0);
      check_latches(req);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      logic av, ak;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!wel && !rwel && !busy && !ack_valid && !commit_valid, "R1 reset outputs",
            int'({wel, rwel, busy, ack_valid, commit_valid}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R11 locked control write
      do_write(8'h10, 2, 8'h11, "R11 locked write");
      // R2 arm wel only, then an unrecognised value
      do_write(8'h3F, 1, 8'h02, "R2 sr 02");
      do_write(8'h3F, 1, 8'h04, "R2 sr other value");
      // R10 read between unlock steps
      ev_pulse(0);
      send(8'hDF, av, ak);
      check(av && ak, "R10 read acked", int'({av, ak}), 3);
      send(8'h00, av, ak);
      ev_pulse(1);
      check_latches("R10 read leaves latches");
      do_write(8'h3F, 1, 8'h06, "R2 sr 06");
      // R4 R6 time bank commit
      do_write(8'h30, 8, 8'h40, "R4 R6 time commit");
      check(!busy && last_busy_run == 0, "R9 time commit no busy", int'(busy), 0);
      // R7 wrong count, R4 misaligned
      do_write(8'h3F, 1, 8'h06, "R2 rearm");
      do_write(8'h30, 7, 8'h50, "R7 time seven bytes");
      do_write(8'h31, 8, 8'h51, "R4 misaligned time");
      // R5 control commit and R9 busy
      do_write(8'h12, 3, 8'h60, "R5 ctrl commit");
      check(busy == 1'b1, "R9 busy after ctrl", int'(busy), 1);
      ev_pulse(0);
      send(8'hDE, av, ak);
      check(av && !ak, "R9 write refused while busy", int'({av, ak}), 2);
      ev_pulse(1);
      ev_pulse(0);
      send(8'hDF, av, ak);
      check(av && ak, "R10 read acked while busy", int'({av, ak}), 3);
      ev_pulse(1);
      repeat (BUSY + 5) @(negedge clk);
      check(!busy && last_busy_run == BUSY, "R9 busy length", last_busy_run, BUSY);
      // R5 crossing end, R7 abort, R7 repeated start, R8 undefined
      do_write(8'h3F, 1, 8'h06, "R2 rearm2");
      do_write(8'h13, 3, 8'h70, "R5 ctrl crosses end");
      ev_pulse(0);
      send(8'hDE, av, ak);
      send(8'h30, av, ak);
      for (int i = 0; i < 8; i++) send(dbyte(8'h80, i), av, ak);
      ev_pulse(2);
      ev_pulse(1);
      repeat (10) @(negedge clk);
      check(q_addr.size() == 0, "R7 abort no commit", q_addr.size(), 0);
      check_latches("R7 abort keeps rwel");
      ev_pulse(0);
      send(8'hDE, av, ak);
      send(8'h10, av, ak);
      send(8'h91, av, ak);
      ev_pulse(0);
      send(8'hDF, av, ak);
      ev_pulse(1);
      repeat (10) @(negedge clk);
      check_latches("R7 repeated start keeps rwel");
      do_write(8'h20, 1, 8'hA0, "R8 undefined address");
      // R3 foreign slave byte
      ev_pulse(0);
      send(8'hA0, av, ak);
      check(av && !ak, "R3 foreign slave nack", int'({av, ak}), 2);
      send(8'h10, av, ak);
      check(!av, "R3 ignored after nack", int'(av), 0);
      ev_pulse(1);
      // R13 ninth byte
      do_write(8'h30, 9, 8'hB0, "R13 nine bytes");
      // R5 full control bank
      do_write(8'h10, 5, 8'hC0, "R5 five bytes");
      repeat (BUSY + 5) @(negedge clk);
      // R2 clear
      do_write(8'h3F, 1, 8'h00, "R2 sr 00");
      done = 1;
      finish_run();
   end

endmodule